// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves 8-bit characters over a serial data pair in step with a single shared serial clock. It transmits and receives at the same time, and both directions run from the same edges of that clock. Each direction has a holding register in front of its shift register. Software can therefore place the next byte for transmission, or collect the last received byte, while a character is still shifting. When the next byte is ready in time, characters follow each other with no gap in the clock.

The serial clock comes from one of two places. In internal mode, a divider toggles the clock every `cfg_half_period` system cycles and the block drives it out. The clock runs only while a character is being shifted, and it rests high otherwise. In external mode the clock pin is an input. It is brought into the system clock domain through a synchronizer, and its detected edges step the same shift logic. Transmit data changes on falling clock edges. Receive data is taken on rising clock edges. After a character, the data line keeps the value of its last bit.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A written byte is sent as exactly eight data bits, bit 0 first and bit 7 last, with no extra bit of any kind. The bits appear on `sd_o` as sampled at the rising edges of the serial clock.
- R2: In internal mode, `sd_o` changes only in the system cycle in which `sck_o` goes from 1 to 0. It then holds until the next such fall.
- R3: `sd_i` is sampled on rising serial clock edges, bit 0 first. After the eighth rising edge the assembled byte appears on `rx_rdata` and `rx_full` goes to 1. A one-cycle `rx_rd` pulse clears `rx_full`.
- R4: Once a character ends and no further one follows, `sd_o` keeps the value of bit 7 of that character.
- R5: In internal mode, `sck_oe` is 1 and the block drives exactly eight clock pulses per character. Each level lasts `cfg_half_period` system cycles, which must be at least 3. `sck_o` is 1 whenever no character is shifting.
- R6: In internal mode, a character starts when a byte is waiting in the transmit holding register. The first falling edge comes two cycles after the write strobe. If the next byte is written before the current character ends, the rising edges keep an even spacing of 2·`cfg_half_period` cycles across the character boundary.
- R7: A write clears `tx_empty` and `tx_end`. `tx_empty` returns to 1 when the byte moves into the shift register. `tx_end` goes to 1 when a character finishes and no byte is waiting.
- R8: If a character completes while `rx_full` is 1, `rx_ovr` goes to 1, the new byte is discarded and `rx_rdata` keeps the older byte. A `rx_ovr_clr` pulse clears `rx_ovr`.
- R9: With `cfg_ext_clk` at 1, `sck_oe` is 0 and `sck_o` rests at 1. Edges of `sck_i`, after a two-stage synchronizer, shift both directions in the same way as in internal mode.
- R10: After reset, `tx_empty`=1, `tx_end`=1, `rx_full`=0, `rx_ovr`=0, `sck_o`=1, `sck_oe`=1 (internal mode) and `sd_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_ext_clk | input | 1 | 1: serial clock comes from `sck_i`; 0: the internal divider drives it |
| cfg_half_period | input | DIV_W | Internal serial clock half period, in system cycles (minimum 3) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| tx_end | output | 1 | Transmitter idle with nothing waiting |
| rx_rd | input | 1 | Acknowledges the received byte and clears `rx_full` |
| rx_rdata | output | 8 | Last received byte |
| rx_full | output | 1 | A received byte is waiting |
| rx_ovr_clr | input | 1 | Clears `rx_ovr` |
| rx_ovr | output | 1 | A character arrived while `rx_full` was set |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable for `sck_o` |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |

## Verification
The hardest case to reach from the ports is the seamless handoff between two characters. The second byte has to land in the holding register after the first byte has left it but before the first character's eighth rising edge, and the clock must not pause at the boundary. The bench writes the second byte as soon as `tx_empty` returns. It timestamps every serial rising edge and checks that their spacing stays uniform across the boundary. A far-end model attached to the serial pins captures `sd_o` and feeds `sd_i` in both clock modes, so full-duplex traffic and receive overrun come from ordinary byte sequences.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned IDX_W  = $clog2(CHAR_W);

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t LAST_IDX = idx_t'(CHAR_W - 1);
endpackage

// File: rtl/ssx_clkgen.sv
// Serial clock source: internal half-period divider or synchronized external pin.
// Emits one-cycle fall/rise events in the system clock domain.
module ssx_clkgen #(
    parameter int unsigned DIV_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] half_period,
    input  logic             run,
    input  logic             sck_ext,
    output logic             sck_out,
    output logic             fall_ev,
    output logic             rise_ev
);
    typedef struct packed {
        logic                   sck;
        logic                   running;
        logic [DIV_W-1:0]       cnt;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } gen_s;

    gen_s q, d;
    logic [DIV_W-1:0] half_m1;
    logic             ext_lvl;

    always_comb begin
        d       = q;
        fall_ev = 1'b0;
        rise_ev = 1'b0;
        half_m1 = (half_period == '0) ? '0 : half_period - 1'b1;
        d.sync  = {q.sync[SYNC_STAGES-2:0], sck_ext};
        ext_lvl = q.sync[SYNC_STAGES-1];
        d.prev  = ext_lvl;
        if (ext_sel) begin
            fall_ev   = q.prev & ~ext_lvl;
            rise_ev   = ~q.prev & ext_lvl;
            d.sck     = 1'b1;
            d.running = 1'b0;
            d.cnt     = '0;
        end else if (!q.running) begin
            if (run) begin
                d.sck     = 1'b0;
                d.running = 1'b1;
                d.cnt     = '0;
                fall_ev   = 1'b1;
            end
        end else if (q.cnt >= half_m1) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck   = 1'b1;
                rise_ev = 1'b1;
            end else if (run) begin
                d.sck   = 1'b0;
                fall_ev = 1'b1;
            end else begin
                d.running = 1'b0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sck     <= 1'b1;
            q.running <= 1'b0;
            q.cnt     <= '0;
            q.sync    <= '1;
            q.prev    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_out = q.sck;

    // R5: the internal clock only leaves its high rest level when a character is pending
    a_r5_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && $fell(q.sck)) |-> $past(run))
        else $error("R5: serial clock fell with nothing to send");

    // R9: in external mode the two event kinds never coincide and the driven clock rests high
    a_r9_ext_events: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && $past(ext_sel)) |-> (q.sck && !(fall_ev && rise_ev)))
        else $error("R9: external mode clock state inconsistent");
endmodule

// File: rtl/ssx_tx.sv
// Transmit unit: holding register plus shift register, stepped by clock events.
module ssx_tx
    import ssx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ext_sel,
    input  logic  wr_en,
    input  char_t wr_data,
    input  logic  fall_ev,
    input  logic  rise_ev,
    output logic  sd_out,
    output logic  run,
    output logic  tx_empty,
    output logic  tx_end
);
    typedef struct packed {
        logic  busy;
        idx_t  rises;
        char_t shreg;
        logic  sd;
        char_t hold;
        logic  hold_full;
        logic  done;
    } tx_s;

    tx_s  q, d;
    logic char_last;

    always_comb begin
        d         = q;
        char_last = 1'b0;
        if (fall_ev) begin
            if (q.busy) begin
                d.sd = q.shreg[q.rises];
            end else if (q.hold_full) begin
                d.shreg     = q.hold;
                d.sd        = q.hold[0];
                d.busy      = 1'b1;
                d.rises     = '0;
                d.hold_full = 1'b0;
            end
        end
        if (rise_ev && q.busy) begin
            if (q.rises == LAST_IDX) begin
                d.busy    = 1'b0;
                d.rises   = '0;
                char_last = 1'b1;
            end else begin
                d.rises = q.rises + 1'b1;
            end
        end
        if (wr_en) begin
            d.hold      = wr_data;
            d.hold_full = 1'b1;
            d.done      = 1'b0;
        end
        if (char_last && !d.hold_full) begin
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy      <= 1'b0;
            q.rises     <= '0;
            q.shreg     <= '0;
            q.sd        <= 1'b1;
            q.hold      <= '0;
            q.hold_full <= 1'b0;
            q.done      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sd_out   = q.sd;
    assign run      = q.busy | q.hold_full;
    assign tx_empty = ~q.hold_full;
    assign tx_end   = q.done;

    // R2: the data line moves only after a falling clock event
    a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(q.sd))
        else $error("R2: transmit data changed without a falling edge");

    // R4: at the end of a character the line carries the last data bit
    a_r4_msb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.sd == q.shreg[LAST_IDX]))
        else $error("R4: line does not hold the last bit");

    // R5: internal rising edges only occur inside a character
    a_r5_pulses_in_char: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && rise_ev) |-> q.busy)
        else $error("R5: extra internal clock pulse");

    // R7: the holding register empties only through a load on a falling edge
    a_r7_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.hold_full) |-> $past(fall_ev))
        else $error("R7: holding register emptied without a load");

    // R7: end flag implies nothing in flight
    a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && !q.hold_full))
        else $error("R7: end flag set while busy");
endmodule

// File: rtl/ssx_rx.sv
// Receive unit: synchronizes the data pin, shifts on rising events, buffers one byte.
module ssx_rx
    import ssx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sd_in,
    input  logic  rise_ev,
    input  logic  rd_en,
    input  logic  ovr_clr,
    output char_t rd_data,
    output logic  full,
    output logic  ovr
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        char_t                  shreg;
        idx_t                   cnt;
        char_t                  rdr;
        logic                   full;
        logic                   ovr;
    } rx_s;

    rx_s   q, d;
    char_t nxt;
    logic  full_eff;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[SYNC_STAGES-2:0], sd_in};
        nxt      = {q.sync[SYNC_STAGES-1], q.shreg[CHAR_W-1:1]};
        full_eff = q.full & ~rd_en;
        d.full   = full_eff;
        if (ovr_clr) begin
            d.ovr = 1'b0;
        end
        if (rise_ev) begin
            d.shreg = nxt;
            if (q.cnt == LAST_IDX) begin
                d.cnt = '0;
                if (full_eff) begin
                    d.ovr = 1'b1;
                end else begin
                    d.rdr  = nxt;
                    d.full = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync  <= '1;
            q.shreg <= '0;
            q.cnt   <= '0;
            q.rdr   <= '0;
            q.full  <= 1'b0;
            q.ovr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rdr;
    assign full    = q.full;
    assign ovr     = q.ovr;

    // R8: an unread byte is never replaced
    a_r8_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !rd_en) |=> $stable(q.rdr))
        else $error("R8: unread byte overwritten");

    // R3: the full flag only rises on a rising serial clock event
    a_r3_full_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> $past(rise_ev))
        else $error("R3: receive full without a clock edge");
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int unsigned DIV_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_clk,
    input  logic [DIV_W-1:0]  cfg_half_period,
    input  logic              tx_wr,
    input  logic [CHAR_W-1:0] tx_wdata,
    output logic              tx_empty,
    output logic              tx_end,
    input  logic              rx_rd,
    output logic [CHAR_W-1:0] rx_rdata,
    output logic              rx_full,
    input  logic              rx_ovr_clr,
    output logic              rx_ovr,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sd_i,
    output logic              sd_o
);
    logic fall_ev, rise_ev, tx_run;

    ssx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_sel     (cfg_ext_clk),
        .half_period (cfg_half_period),
        .run         (tx_run),
        .sck_ext     (sck_i),
        .sck_out     (sck_o),
        .fall_ev     (fall_ev),
        .rise_ev     (rise_ev)
    );

    ssx_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sel  (cfg_ext_clk),
        .wr_en    (tx_wr),
        .wr_data  (tx_wdata),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .sd_out   (sd_o),
        .run      (tx_run),
        .tx_empty (tx_empty),
        .tx_end   (tx_end)
    );

    ssx_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sd_in   (sd_i),
        .rise_ev (rise_ev),
        .rd_en   (rx_rd),
        .ovr_clr (rx_ovr_clr),
        .rd_data (rx_rdata),
        .full    (rx_full),
        .ovr     (rx_ovr)
    );

    assign sck_oe = ~cfg_ext_clk;

    // R5: with the transmitter finished, the internal clock rests high
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && tx_end) |-> sck_o)
        else $error("R5: serial clock low while idle");
endmodule

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_ext_clk = 1'b0;
    logic [DIV_W-1:0] cfg_half_period = 12'd4;
    logic             tx_wr = 1'b0;
    logic [7:0]       tx_wdata = 8'h00;
    logic             rx_rd = 1'b0;
    logic             rx_ovr_clr = 1'b0;
    logic             ext_sck = 1'b1;
    logic             sd_i_drv = 1'b1;
    logic             tx_empty, tx_end, rx_full, rx_ovr, sck_o, sck_oe, sd_o;
    logic [7:0]       rx_rdata;
    logic             sck_line;

    always #5 clk = ~clk;

    sync_serial_xcvr #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk),
        .cfg_half_period(cfg_half_period), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_empty(tx_empty), .tx_end(tx_end), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_full(rx_full), .rx_ovr_clr(rx_ovr_clr), .rx_ovr(rx_ovr),
        .sck_i(ext_sck), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i_drv), .sd_o(sd_o)
    );

    assign sck_line = cfg_ext_clk ? ext_sck : sck_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wd_fail  = 0;
    int cyc      = 0;

    // far-end model state (written only by the monitors)
    logic [63:0] capv = '0;
    int          rise_cnt = 0;
    int          fe_idx = 0;
    int          gap_bad = 0;
    time         last_rise = 0;
    int          r2_bad = 0;
    logic        sd_prev = 1'b1;
    logic        sck_prev = 1'b1;

    // far-end stimulus (written only by the main sequence)
    logic [31:0] fe_word = '1;
    int          fe_base = 0;
    int          rise_base = 0;
    int          gap_base = 0;
    time         exp_gap = 0;

    always @(posedge sck_line) begin
        if ((rise_cnt - rise_base) > 0 && exp_gap != 0 && ($time - last_rise) != exp_gap)
            gap_bad++;
        last_rise = $time;
        capv[rise_cnt % 64] = sd_o;
        rise_cnt++;
    end

    always @(negedge sck_line) begin
        sd_i_drv = fe_word[(fe_idx - fe_base) % 32];
        fe_idx++;
    end

    always @(negedge clk) begin
        if (rst_n && !cfg_ext_clk && sd_o != sd_prev && !(sck_prev == 1'b1 && sck_o == 1'b0))
            r2_bad++;
        sd_prev  = sd_o;
        sck_prev = sck_o;
    end

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + wd_fail, n_fail + wd_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected below 150000)", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = capv[(rise_base + 8 * k + i) % 64];
        return b;
    endfunction

    task automatic arm(input logic [15:0] fe, input int h, input bit chk_gap);
        fe_word   = {16'hFFFF, fe};
        fe_base   = fe_idx;
        rise_base = rise_cnt;
        gap_base  = gap_bad;
        exp_gap   = chk_gap ? time'(2 * h * 10) : time'(0);
        cfg_half_period = DIV_W'(h);
    endtask

    task automatic write_tx(input logic [7:0] v);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_wdata = v;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_rx;
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!tx_end && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(tx_end == 1'b1, req, 32'(tx_end), 32'd1);
    endtask

    task automatic ext_char(input int h);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ext_sck = 1'b0;
            repeat (h) @(negedge clk);
            ext_sck = 1'b1;
            repeat (h - 1) @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] tb_b, fe_b;
        int h, n;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(tx_empty == 1'b1, "R10 tx_empty", 32'(tx_empty), 32'd1);
        check(tx_end == 1'b1, "R10 tx_end", 32'(tx_end), 32'd1);
        check(rx_full == 1'b0, "R10 rx_full", 32'(rx_full), 32'd0);
        check(rx_ovr == 1'b0, "R10 rx_ovr", 32'(rx_ovr), 32'd0);
        check(sck_o == 1'b1 && sck_oe == 1'b1, "R10 sck", {30'd0, sck_o, sck_oe}, 32'd3);
        check(sd_o == 1'b1, "R10 sd_o", 32'(sd_o), 32'd1);

        // directed single character, internal clock
        arm(16'hFF3C, 4, 1'b1);
        write_tx(8'h5A);
        check(tx_empty == 1'b0 && tx_end == 1'b0, "R7 flags after write", {30'd0, tx_empty, tx_end}, 32'd0);
        @(negedge clk);
        check(tx_empty == 1'b1, "R7 empty after load", 32'(tx_empty), 32'd1);
        check(sck_o == 1'b0, "R6 first fall two cycles after write", 32'(sck_o), 32'd0);
        wait_end("R7 end after char");
        repeat (3) @(negedge clk);
        check(cap_byte(0) == 8'h5A, "R1 lsb first", 32'(cap_byte(0)), 32'h5A);
        check(rise_cnt - rise_base == 8, "R5 eight pulses", 32'(rise_cnt - rise_base), 32'd8);
        check(gap_bad == gap_base, "R5 half period", 32'(gap_bad - gap_base), 32'd0);
        check(rx_full == 1'b1 && rx_rdata == 8'h3C, "R3 receive byte", {23'd0, rx_full, rx_rdata}, 32'h13C);
        check(sd_o == 1'b0, "R4 msb held", 32'(sd_o), 32'd0);
        repeat (10) @(negedge clk);
        check(sck_o == 1'b1 && sd_o == 1'b0, "R5 idle high, R4 hold", {30'd0, sck_o, sd_o}, 32'd2);
        read_rx();
        check(rx_full == 1'b0, "R3 read clears full", 32'(rx_full), 32'd0);

        // back-to-back characters
        arm({8'hC3, 8'h81}, 3, 1'b1);
        write_tx(8'h96);
        n = 0;
        while (!tx_empty && n < 100) begin @(negedge clk); n++; end
        write_tx(8'h0F);
        n = 0;
        while (!rx_full && n < 500) begin @(negedge clk); n++; end
        check(rx_rdata == 8'h81, "R3 first of pair", 32'(rx_rdata), 32'h81);
        read_rx();
        wait_end("R7 end after pair");
        repeat (3) @(negedge clk);
        check(cap_byte(0) == 8'h96, "R1 pair byte 0", 32'(cap_byte(0)), 32'h96);
        check(cap_byte(1) == 8'h0F, "R1 pair byte 1", 32'(cap_byte(1)), 32'h0F);
        check(rise_cnt - rise_base == 16, "R6 sixteen pulses", 32'(rise_cnt - rise_base), 32'd16);
        check(gap_bad == gap_base, "R6 no idle clock between chars", 32'(gap_bad - gap_base), 32'd0);
        check(rx_full && rx_rdata == 8'hC3 && !rx_ovr, "R3 second of pair", {22'd0, rx_ovr, rx_full, rx_rdata}, 32'h1C3);
        read_rx();

        // overrun
        arm({8'h44, 8'h11}, 5, 1'b0);
        write_tx(8'hE7);
        wait_end("R7 end overrun 1");
        write_tx(8'h18);
        wait_end("R7 end overrun 2");
        repeat (3) @(negedge clk);
        check(cap_byte(0) == 8'hE7 && cap_byte(1) == 8'h18, "R1 overrun bytes",
              {16'd0, cap_byte(0), cap_byte(1)}, 32'hE718);
        check(rx_ovr == 1'b1, "R8 overrun flag", 32'(rx_ovr), 32'd1);
        check(rx_full && rx_rdata == 8'h11, "R8 older byte kept", {23'd0, rx_full, rx_rdata}, 32'h111);
        @(negedge clk); rx_ovr_clr = 1'b1;
        @(negedge clk); rx_ovr_clr = 1'b0;
        check(rx_ovr == 1'b0, "R8 overrun clear", 32'(rx_ovr), 32'd0);
        read_rx();

        // random traffic, internal clock
        for (int it = 0; it < 24; it++) begin
            h = 3 + int'($urandom % 4);
            tb_b = 8'($urandom);
            fe_b = 8'($urandom);
            arm({8'hFF, fe_b}, h, 1'b1);
            write_tx(tb_b);
            wait_end("R7 random end");
            repeat (2) @(negedge clk);
            check(cap_byte(0) == tb_b, "R1 random tx", 32'(cap_byte(0)), 32'(tb_b));
            check(rx_full && rx_rdata == fe_b, "R3 random rx", {23'd0, rx_full, rx_rdata}, {23'd0, 1'b1, fe_b});
            check(sd_o == tb_b[7], "R4 random msb hold", 32'(sd_o), 32'(tb_b[7]));
            check(rise_cnt - rise_base == 8 && gap_bad == gap_base, "R5 random pulses",
                  32'(rise_cnt - rise_base), 32'd8);
            read_rx();
        end
        check(r2_bad == 0, "R2 data moves only on falling edge", 32'(r2_bad), 32'd0);

        // external clock
        @(negedge clk); cfg_ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        check(sck_oe == 1'b0 && sck_o == 1'b1, "R9 clock pin released", {30'd0, sck_oe, sck_o}, 32'd1);
        for (int it = 0; it < 6; it++) begin
            tb_b = 8'($urandom);
            fe_b = 8'($urandom);
            arm({8'hFF, fe_b}, 8, 1'b0);
            write_tx(tb_b);
            ext_char(8);
            repeat (6) @(negedge clk);
            check(cap_byte(0) == tb_b, "R9 external tx", 32'(cap_byte(0)), 32'(tb_b));
            check(rx_full && rx_rdata == fe_b, "R9 external rx", {23'd0, rx_full, rx_rdata}, {23'd0, 1'b1, fe_b});
            check(tx_end == 1'b1, "R7 external end", 32'(tx_end), 32'd1);
            read_rx();
        end
        @(negedge clk); cfg_ext_clk = 1'b0;
        repeat (2) @(negedge clk);
        check(sck_oe == 1'b1 && sck_o == 1'b1, "R5 clock driven again", {30'd0, sck_oe, sck_o}, 32'd3);

        finish_run();
    end
endmodule